// File: doc/BRIEF.md
# Interleaved Bank Block Fetch Controller

This block serves cache-line reads from a set of word-interleaved memory banks. A cache line is four 32-bit words, and word address `w` lives in bank `w mod 4` at row `w / 4`. When the cache side presents a block address, the controller drives that row to every bank during one address cycle. All banks then run their six-cycle access side by side. After that, the four words go back to the cache over a single 32-bit return path, one word per cycle, lowest word first.

Each returned word carries a valid strobe and a 2-bit word index, so the cache can place the word in its line. The controller takes one block at a time. It raises its ready output again only once the last word of the current block has been returned. A whole fetch takes 1 + 6 + 4 = 11 cycles. Four back-to-back single-bank accesses would take 32.

A word-granular write port fills the banks. The port steers each write to a bank by the low address bits, and it only takes effect while the controller is idle.

Top module: `ilv_block_ctrl`

## Requirements
- R1: After reset, or when reset is applied in the middle of a fetch, `req_ready` is 1 and `rsp_valid` is 0; a fetch cut short by reset returns no further words.
- R2: A write of `wr_data` to word address `wr_addr` while idle lands in bank `wr_addr[1:0]` at row `wr_addr[7:2]`; a later fetch of block `wr_addr[7:2]` returns that data at index `wr_addr[1:0]`.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1; `req_ready` is 0 from the next cycle on.
- R4: Counting the accepting edge as edge 0, `rsp_valid` first becomes 1 after edge 7 (1 address cycle plus 6 access cycles).
- R5: The words of a block return on consecutive cycles with `rsp_idx` = 0, 1, 2, 3 in that order, and `rsp_data` equals the word at address `{block, rsp_idx}`.
- R6: `rsp_valid` is 0 after edge 11, and `req_ready` is 1 from then on, so a block occupies exactly 11 cycles.
- R7: `req_valid` asserted while `req_ready` is 0 is ignored: no second block is fetched and no extra words appear.
- R8: A write presented while `req_ready` is 0 does not change any bank.
- R9: Each accepted request produces exactly four cycles with `rsp_valid` = 1.
- R10: All banks present their data when the transfer of the first word begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Block read request |
| req_blk | input | 6 | Block address (row in every bank) |
| req_ready | output | 1 | Controller idle, request can be taken |
| wr_en | input | 1 | Word write strobe (effective only when idle) |
| wr_addr | input | 8 | Word address; low 2 bits pick the bank |
| wr_data | input | 32 | Word write data |
| rsp_valid | output | 1 | Returned word valid |
| rsp_idx | output | 2 | Position of the returned word in the block |
| rsp_data | output | 32 | Returned word |

## Verification
The assertions watch several things on every cycle. Ready drops after acceptance. The first word arrives exactly eight sampled cycles after acceptance, measured by an independent counter. The index climbs by one across the burst and is followed by idle. All banks are valid when the burst starts, and at most one bank is written at a time. Only the bench scenarios can show that the right data comes from the right bank and row. They also show that requests and writes made while busy leave no trace, and that a reset in the middle of a burst abandons it cleanly. For these checks the bench compares each returned word against a pattern it computes from the word address.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_XFER   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ilv_bank.sv
// One memory bank: synchronous array behind a fixed-latency read pipeline.
module ilv_bank #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 6,
  parameter int LAT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ROW_W-1:0]  rrow,
  output logic [WORD_W-1:0] rdata,
  output logic              rvld
);
  localparam int DEPTH = 1 << ROW_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [LAT-1:0]    vld_q;
  logic [LAT-1:0]    vld_d;
  logic [WORD_W-1:0] dq [LAT];

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= wdata;
  end

  always_comb vld_d = {vld_q[LAT-2:0], re};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // data stages advance only behind their valid bit, so the last stage holds
  always_ff @(posedge clk) begin
    if (re) dq[0] <= mem[rrow];
    for (int s = 1; s < LAT; s++) begin
      if (vld_q[s-1]) dq[s] <= dq[s-1];
    end
  end

  assign rdata = dq[LAT-1];
  assign rvld  = vld_q[LAT-1];
endmodule

// File: rtl/ilv_wr_decode.sv
// Steers a word write to the bank named by the low address bits.
module ilv_wr_decode #(
  parameter int NB    = 4,
  parameter int ROW_W = 6
) (
  input  logic                          wr_en,
  input  logic                          allow,
  input  logic [ROW_W+$clog2(NB)-1:0]   wr_addr,
  output logic [NB-1:0]                 bank_we,
  output logic [ROW_W-1:0]              wr_row
);
  localparam int IDX_W = $clog2(NB);

  assign wr_row = wr_addr[ROW_W+IDX_W-1:IDX_W];

  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign bank_we[b] = wr_en && allow && (wr_addr[IDX_W-1:0] == IDX_W'(b));
  end
endmodule

// File: rtl/ilv_seq.sv
// Request acceptance, access timing and serialisation of the returned words.
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 6,
  parameter int LAT    = 6,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ROW_W-1:0]        req_blk,
  output logic                    req_ready,
  output logic                    rd_en,
  output logic [ROW_W-1:0]        rd_row,
  input  logic [NB*WORD_W-1:0]    bank_rdata,
  output logic                    rsp_valid,
  output logic [$clog2(NB)-1:0]   rsp_idx,
  output logic [WORD_W-1:0]       rsp_data
);
  localparam int IDX_W = $clog2(NB);
  localparam int CNT_W = $clog2(LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NB - 1);
  localparam int CHK_W = $clog2(LAT + NB + 4) + 1;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ROW_W-1:0]  blk_q, blk_d;
  logic              vld_q, vld_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [IDX_W-1:0]  sel;
  logic              blk_en;
  logic [WORD_W-1:0] words [NB];

  for (genvar b = 0; b < NB; b++) begin : g_unpack
    assign words[b] = bank_rdata[b*WORD_W +: WORD_W];
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    blk_d   = blk_q;
    vld_d   = vld_q;
    idx_d   = idx_q;
    sel     = '0;
    blk_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          blk_en  = 1'b1;
          blk_d   = req_blk;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        cnt_d   = '0;
        state_d = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_XFER;
          vld_d   = 1'b1;
          idx_d   = '0;
          sel     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_XFER: begin
        if (idx_q == IDX_LAST) begin
          vld_d   = 1'b0;
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          sel   = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    data_d = words[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      blk_q   <= '0;
      vld_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (blk_en) blk_q <= blk_d;
      vld_q   <= vld_d;
      idx_q   <= idx_d;
    end
  end

  // datapath register without reset, loaded only when a word is issued
  always_ff @(posedge clk) begin
    if (vld_d) data_q <= data_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rd_en     = (state_q == ST_ADDR);
  assign rd_row    = blk_q;
  assign rsp_valid = vld_q;
  assign rsp_idx   = idx_q;
  assign rsp_data  = data_q;

  // independent cycle counter for the first-word timing check
  logic [CHK_W-1:0] chk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      chk_q <= '0;
    else if (req_valid && req_ready) chk_q <= CHK_W'(1);
    else if (!req_ready)             chk_q <= chk_q + 1'b1;
  end

  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_blk_held: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(blk_q));

  a_r4_first_word_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (chk_q == CHK_W'(LAT + 2)));

  a_r5_first_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rsp_idx == '0));

  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_idx != IDX_LAST) |=> (rsp_valid && rsp_idx == $past(rsp_idx) + 1'b1));

  a_r9_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_idx == IDX_LAST) |=> (!rsp_valid && req_ready));
endmodule

// File: rtl/ilv_block_ctrl.sv
// Top: reset release synchroniser, write steering, bank array and sequencer.
module ilv_block_ctrl #(
  parameter int NB     = 4,
  parameter int ROW_W  = 6,
  parameter int LAT    = 6,
  parameter int WORD_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [ROW_W-1:0]              req_blk,
  output logic                          req_ready,
  input  logic                          wr_en,
  input  logic [ROW_W+$clog2(NB)-1:0]   wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  output logic                          rsp_valid,
  output logic [$clog2(NB)-1:0]         rsp_idx,
  output logic [WORD_W-1:0]             rsp_data
);
  logic [1:0]           rst_pipe;
  logic                 rst_s_n;
  logic [NB-1:0]        bank_we;
  logic [ROW_W-1:0]     wr_row;
  logic                 rd_en;
  logic [ROW_W-1:0]     rd_row;
  logic [NB*WORD_W-1:0] bank_rdata;
  logic [NB-1:0]        bank_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  ilv_wr_decode #(.NB(NB), .ROW_W(ROW_W)) u_dec (
    .wr_en   (wr_en),
    .allow   (req_ready),
    .wr_addr (wr_addr),
    .bank_we (bank_we),
    .wr_row  (wr_row)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ilv_bank #(.WORD_W(WORD_W), .ROW_W(ROW_W), .LAT(LAT)) u_bank (
      .clk   (clk),
      .rst_n (rst_s_n),
      .we    (bank_we[b]),
      .wrow  (wr_row),
      .wdata (wr_data),
      .re    (rd_en),
      .rrow  (rd_row),
      .rdata (bank_rdata[b*WORD_W +: WORD_W]),
      .rvld  (bank_vld[b])
    );
  end

  ilv_seq #(.NB(NB), .ROW_W(ROW_W), .LAT(LAT), .WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .req_valid  (req_valid),
    .req_blk    (req_blk),
    .req_ready  (req_ready),
    .rd_en      (rd_en),
    .rd_row     (rd_row),
    .bank_rdata (bank_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_idx    (rsp_idx),
    .rsp_data   (rsp_data)
  );

  a_r10_banks_ready: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rsp_valid) |-> $past(&bank_vld));

  a_r2_one_bank_written: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(bank_we));

  a_r8_write_only_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|bank_we) |-> (wr_en && req_ready));
endmodule

// File: tb/ilv_block_ctrl_tb.sv
module ilv_block_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int ROW_W  = 6;
  localparam int AW     = 8;
  localparam int NV     = 6;
  localparam logic [5:0] VICTIM = 6'd5;
  // table entry: {inject-while-busy, block address}
  localparam logic [6:0] VEC [NV] = '{
    {1'b0, 6'd0}, {1'b0, 6'd63}, {1'b1, 6'd17},
    {1'b0, 6'd5}, {1'b0, 6'd42}, {1'b0, 6'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [ROW_W-1:0] req_blk;
  logic          req_ready;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic          rsp_valid;
  logic [1:0]    rsp_idx;
  logic [31:0]   rsp_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  ilv_block_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .req_ready(req_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] pat(input int wa);
    return {8'h5A, wa[7:0], 16'(wa * 1811)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Request one block and check every cycle from the accepting edge (edge 0) to edge 11
  task automatic run_block(input logic [5:0] blk, input bit inj);
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_blk   = blk;
    @(posedge clk);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (n == 0) req_valid = 1'b0;
      if (n >= 7 && n <= 10) begin
        chk(rsp_valid == 1'b1, (n == 7) ? "R4 first word valid" : "R9 word valid", 32'(rsp_valid), 32'd1);
        chk(rsp_idx == 2'(n - 7), "R5 word index", 32'(rsp_idx), 32'(n - 7));
        chk(rsp_data == pat({blk, 2'(n - 7)}),
            (blk == VICTIM && n == 9) ? "R8 busy write ignored" :
            (n == 7) ? "R10 R2 word data" : "R2 R5 word data",
            rsp_data, pat({blk, 2'(n - 7)}));
      end else begin
        chk(rsp_valid == 1'b0, (n < 7) ? "R4 no early word" : "R6 burst over", 32'(rsp_valid), 32'd0);
      end
      chk(req_ready == (n >= 11), (n >= 11) ? "R6 ready after 11" : "R3 busy", 32'(req_ready), 32'(n >= 11));
      if (inj && n == 2) begin
        req_valid = 1'b1;
        req_blk   = blk ^ 6'h15;
        wr_en     = 1'b1;
        wr_addr   = {VICTIM, 2'd2};
        wr_data   = 32'hDEAD_BEEF;
      end
      if (inj && n == 4) begin
        req_valid = 1'b0;
        wr_en     = 1'b0;
      end
    end
    if (inj) begin
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 busy request ignored", 32'(rsp_valid), 32'd0);
      end
      chk(req_ready == 1'b1, "R7 still idle", 32'(req_ready), 32'd1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_blk = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 reset valid", 32'(rsp_valid), 32'd0);

    // fill every bank through the write port
    for (int wa = 0; wa < 256; wa++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(wa); wr_data = pat(wa);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // stimulus table
    for (int i = 0; i < NV; i++) begin
      run_block(VEC[i][5:0], VEC[i][6]);
    end

    // R2: single-word rewrite lands only at its own index
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {6'd42, 2'd3}; wr_data = pat({6'd42, 2'd3});
    @(negedge clk);
    wr_en = 1'b0;
    run_block(6'd42, 1'b0);

    // back-to-back requests: new request on the first idle cycle
    run_block(6'd33, 1'b0);
    run_block(6'd34, 1'b0);

    // R1: reset in the middle of a burst
    @(negedge clk);
    req_valid = 1'b1; req_blk = 6'd9;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(rsp_valid == 1'b0, "R1 reset mid burst valid", 32'(rsp_valid), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after mid reset", 32'(req_ready), 32'd1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1 abandoned burst silent", 32'(rsp_valid), 32'd0);
    end
    run_block(6'd9, 1'b0);

    summary();
  end
endmodule